// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous line frame. The frame is a low start bit, then 5 to 8 data bits sent least-significant first, then an optional parity bit, then a high stop period of one, one and a half or two bit times. All bit timing comes from an oversampling enable pulse, `os_tick`, which an external rate generator raises once per sixteenth of a bit. The block has no divisor of its own.

Characters arrive on a valid/ready stream. A character is taken on a clock edge where `in_valid` and `in_ready` are both high. The line configuration fields are captured on that same edge, so they may change freely while a frame is on the wire. The source holds `in_valid` and `in_data` steady while `in_ready` is low. `in_ready` is high whenever the transmitter is idle. While a frame is running, it rises only in the cycle that holds the last stop tick, so a waiting character follows with no idle gap.

A break input pulls the line to the spacing level for as long as it is high. Frame timing and character acceptance carry on underneath it.

Top module: `async_char_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character and the values of `cfg_len`, `cfg_par_en`, `cfg_par_even` and `cfg_stop_ext` are captured on an edge where `in_valid` and `in_ready` are both 1. Changing these inputs later has no effect on the running frame. While a frame is running, `in_ready` is 0 except in the cycle holding the final stop tick.
- R3: In the cycle after acceptance, `txd` goes to 0 for the start bit. The start bit lasts 16 `os_tick` pulses.
- R4: The data bits follow the start bit, least-significant first, each lasting 16 ticks. The bit count is `cfg_len` + 5 (code 0 gives 5 bits, code 3 gives 8 bits).
- R5: With `cfg_par_en` = 1, one parity bit of 16 ticks follows the data. With `cfg_par_even` = 1 it is the XOR of the sent data bits; with `cfg_par_even` = 0 it is the inverse of that XOR. With `cfg_par_en` = 0 there is no parity bit.
- R6: The stop period is high. It lasts 16 ticks when `cfg_stop_ext` = 0, 24 ticks when `cfg_stop_ext` = 1 and `cfg_len` = 0, and 32 ticks when `cfg_stop_ext` = 1 and `cfg_len` is 1 to 3.
- R7: A character accepted in the final stop tick begins its start bit in the very next cycle.
- R8: Frame timing advances only in cycles where `os_tick` = 1. Without ticks, the line and `busy` hold their values.
- R9: While `brk_force` = 1, `txd` is 0 in every state. Frames keep their timing, and characters are still accepted. When `brk_force` is released, `txd` again shows the current frame bit.
- R10: `busy` is 1 from the cycle after acceptance until the final stop tick has passed. It is then 0 unless a new character was taken at that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling enable, one pulse per 1/16 bit |
| in_data | input | 8 | Character to send |
| in_valid | input | 1 | Character present on `in_data` |
| in_ready | output | 1 | Transmitter can take a character this cycle |
| cfg_len | input | 2 | Data bit count minus 5 |
| cfg_par_en | input | 1 | Append a parity bit |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| cfg_stop_ext | input | 1 | 0 selects one stop bit; 1 selects 1.5 (5-bit words) or 2 stop bits |
| brk_force | input | 1 | Hold the line at the spacing level |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |

## Verification
With `os_tick` held high, the frame bit numbered b (the start bit is b = 0) occupies cycles 16b through 16b+15 after the accepting edge. The bench therefore samples each bit at offset 16b+8, at the falling clock edge.

The frame ends at offset T = 16·(1 + bits + parity) + stop ticks. The bench checks that `in_ready` is 0 at T−2 and 1 at T−1, and that `busy` has cleared at T. Those three samples bound the stop length to a single cycle.

`brk_force` reaches `txd` with no register in the path, so break checks sample in the same cycle the level changes. The no-tick hold check waits many cycles with ticks stopped before sampling.

// File: rtl/async_char_tx_pkg.sv
package async_char_tx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_phase_e;

  localparam int CHAR_W   = 8;
  localparam int LEN_W    = 2;
  localparam int MIN_BITS = 5;

endpackage

// File: rtl/tx_parity_calc.sv
module tx_parity_calc
  import async_char_tx_pkg::*;
(
  input  logic [CHAR_W-1:0] char_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              even_o
);

  logic acc;

  always_comb begin
    acc = 1'b0;
    for (int i = 0; i < CHAR_W; i++) begin
      if (i < int'(len_i) + MIN_BITS) acc = acc ^ char_i[i];
    end
    even_o = acc;
  end

endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
  import async_char_tx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int STOP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [2:0]        data_last_i,
  input  logic              par_en_i,
  input  logic [STOP_W-1:0] stop_last_i,
  output tx_phase_e         phase_o,
  output logic [2:0]        bit_idx_o,
  output logic              frame_end_o
);

  localparam int CNT_W = $clog2(OVS);

  tx_phase_e         phase_q;
  logic [CNT_W-1:0]  tick_cnt_q;
  logic [2:0]        bit_idx_q;
  logic [STOP_W-1:0] stop_cnt_q;
  logic              bit_end;

  assign bit_end     = tick_i && (tick_cnt_q == CNT_W'(OVS - 1));
  assign frame_end_o = (phase_q == TX_STOP) && tick_i && (stop_cnt_q == stop_last_i);
  assign phase_o     = phase_q;
  assign bit_idx_o   = bit_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q    <= TX_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      stop_cnt_q <= '0;
    end else begin
      case (phase_q)
        TX_IDLE: begin
          tick_cnt_q <= '0;
          if (load_i) phase_q <= TX_START;
        end
        TX_START: begin
          tick_cnt_q <= bit_end ? '0 : tick_cnt_q + CNT_W'(tick_i);
          if (bit_end) begin
            phase_q   <= TX_DATA;
            bit_idx_q <= '0;
          end
        end
        TX_DATA: begin
          tick_cnt_q <= bit_end ? '0 : tick_cnt_q + CNT_W'(tick_i);
          if (bit_end) begin
            if (bit_idx_q == data_last_i) begin
              phase_q    <= par_en_i ? TX_PAR : TX_STOP;
              stop_cnt_q <= '0;
            end else begin
              bit_idx_q <= bit_idx_q + 3'd1;
            end
          end
        end
        TX_PAR: begin
          tick_cnt_q <= bit_end ? '0 : tick_cnt_q + CNT_W'(tick_i);
          if (bit_end) begin
            phase_q    <= TX_STOP;
            stop_cnt_q <= '0;
          end
        end
        TX_STOP: begin
          tick_cnt_q <= '0;
          if (frame_end_o) phase_q <= load_i ? TX_START : TX_IDLE;
          else stop_cnt_q <= stop_cnt_q + STOP_W'(tick_i);
        end
        default: phase_q <= TX_IDLE;
      endcase
    end
  end

  // R8
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != TX_IDLE) && !tick_i |=> $stable(phase_q) && $stable(tick_cnt_q) && $stable(stop_cnt_q));

  // R6
  stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TX_STOP) |-> (stop_cnt_q <= stop_last_i));

  // R4
  data_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TX_DATA) |-> (bit_idx_q <= data_last_i));

endmodule

// File: rtl/async_char_tx.sv
module async_char_tx
  import async_char_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_stop_ext,
  input  logic              brk_force,
  output logic              txd,
  output logic              busy
);

  localparam int STOP_W = $clog2(2 * OVS);

  logic [CHAR_W-1:0] char_q;
  logic [LEN_W-1:0]  len_q;
  logic              par_en_q;
  logic              par_even_q;
  logic [STOP_W-1:0] stop_last_q;
  logic [STOP_W-1:0] stop_last_d;
  logic              accept;
  logic              frame_end;
  logic              even_par;
  logic              line;
  logic [2:0]        bit_idx;
  tx_phase_e         phase;

  assign accept = in_valid && in_ready;

  always_comb begin
    if (!cfg_stop_ext)     stop_last_d = STOP_W'(OVS - 1);
    else if (cfg_len == 0) stop_last_d = STOP_W'(OVS + OVS / 2 - 1);
    else                   stop_last_d = STOP_W'(2 * OVS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      char_q      <= '0;
      len_q       <= '0;
      par_en_q    <= 1'b0;
      par_even_q  <= 1'b0;
      stop_last_q <= STOP_W'(OVS - 1);
    end else if (accept) begin
      char_q      <= in_data;
      len_q       <= cfg_len;
      par_en_q    <= cfg_par_en;
      par_even_q  <= cfg_par_even;
      stop_last_q <= stop_last_d;
    end
  end

  tx_parity_calc u_par (
    .char_i (char_q),
    .len_i  (len_q),
    .even_o (even_par)
  );

  tx_frame_seq #(.OVS(OVS), .STOP_W(STOP_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (os_tick),
    .load_i      (accept),
    .data_last_i ({1'b0, len_q} + 3'd4),
    .par_en_i    (par_en_q),
    .stop_last_i (stop_last_q),
    .phase_o     (phase),
    .bit_idx_o   (bit_idx),
    .frame_end_o (frame_end)
  );

  always_comb begin
    case (phase)
      TX_START: line = 1'b0;
      TX_DATA:  line = char_q[bit_idx];
      TX_PAR:   line = par_even_q ? even_par : ~even_par;
      default:  line = 1'b1;
    endcase
  end

  assign in_ready = (phase == TX_IDLE) || frame_end;
  assign busy     = (phase != TX_IDLE);
  assign txd      = brk_force ? 1'b0 : line;

  // R2
  ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready && busy |-> os_tick);

  // R3
  start_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy && (brk_force || !txd));

  // R1
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !brk_force |-> txd);

  // R10
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(in_ready) && !$past(in_valid));

endmodule

// File: tb/test_async_char_tx.sv
module test_async_char_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] cfg_len = '0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_stop_ext = 1'b0;
  logic       brk_force = 1'b0;
  logic       txd;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;
  int rel = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  async_char_tx i_async_char_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop_ext(cfg_stop_ext), .brk_force(brk_force),
    .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_to(input int m);
    while (rel < m) begin
      @(negedge clk);
      rel++;
    end
  endtask

  // Raise valid, wait for ready, return at the falling edge after acceptance (rel = 0).
  task automatic accept_char(input logic [7:0] d);
    in_data  = d;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rel = 0;
  endtask

  function automatic int stop_ticks(input int len, input int ext);
    if (ext == 0) return 16;
    if (len == 0) return 24;
    return 32;
  endfunction

  task automatic check_frame(input logic [7:0] d, input int len, input int pe,
                             input int pev, input int ext);
    int n = len + 5;
    int s = stop_ticks(len, ext);
    int t = 16 * (1 + n + pe) + s;
    bit p = 1'b0;
    for (int i = 0; i < n; i++) p = p ^ d[i];
    if (pev == 0) p = ~p;
    wait_to(8);
    check(txd == 1'b0, "R3", txd, 0);
    check(busy == 1'b1, "R10", busy, 1);
    for (int b = 0; b < n; b++) begin
      wait_to(16 * (b + 1) + 8);
      check(txd == d[b], "R4", txd, d[b]);
    end
    if (pe != 0) begin
      wait_to(16 * (n + 1) + 8);
      check(txd == p, "R5", txd, p);
    end
    wait_to(16 * (1 + n + pe) + s / 2);
    check(txd == 1'b1, "R6", txd, 1);
    wait_to(t - 2);
    check(in_ready == 1'b0, "R2", in_ready, 0);
    wait_to(t - 1);
    check(in_ready == 1'b1 && busy == 1'b1, "R6", {in_ready, busy}, 3);
    wait_to(t);
    check(busy == 1'b0 && txd == 1'b1, "R10", {busy, txd}, 1);
  endtask

  task automatic run_frame(input logic [7:0] d, input int len, input int pe,
                           input int pev, input int ext);
    cfg_len = 2'(len); cfg_par_en = pe[0]; cfg_par_even = pev[0]; cfg_stop_ext = ext[0];
    accept_char(d);
    check_frame(d, len, pe, pev, ext);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1", txd, 1);
    check(busy == 1'b0, "R1", busy, 0);
    check(in_ready == 1'b1, "R1", in_ready, 1);

    // Sweep over every configuration (R3 R4 R5 R6 R10)
    for (int cfg = 0; cfg < 32; cfg++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d = 8'(8'h5A ^ (cfg * 37 + k * 91));
        run_frame(d, cfg & 3, (cfg >> 2) & 1, (cfg >> 3) & 1, (cfg >> 4) & 1);
        @(negedge clk);
      end
    end

    // R2 / R7: back-to-back with new config captured at acceptance
    cfg_len = 2'd0; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_stop_ext = 1'b0;
    accept_char(8'h15);
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop_ext = 1'b1;
    in_data = 8'hC3; in_valid = 1'b1;
    wait_to(40);
    check(in_ready == 1'b0, "R2", in_ready, 0);
    wait_to(111);
    check(in_ready == 1'b1, "R2", in_ready, 1);
    wait_to(112);
    check(busy == 1'b1 && txd == 1'b0, "R7", {busy, txd}, 2);
    in_valid = 1'b0;
    rel = 0;
    check_frame(8'hC3, 3, 1, 1, 1);

    // R8: no ticks, nothing moves
    @(negedge clk);
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stop_ext = 1'b0;
    accept_char(8'hFF);
    os_tick = 1'b0;
    wait_to(60);
    check(txd == 1'b0 && busy == 1'b1, "R8", {txd, busy}, 1);
    os_tick = 1'b1;
    rel = 0;
    wait_to(24);
    check(txd == 1'b1, "R8", txd, 1);
    wait_to(160);
    check(busy == 1'b0, "R8", busy, 0);

    // R9: break mid-frame and from idle
    @(negedge clk);
    accept_char(8'hFF);
    wait_to(8);
    brk_force = 1'b1;
    #1;
    check(txd == 1'b0, "R9", txd, 0);
    wait_to(40);
    check(txd == 1'b0 && busy == 1'b1, "R9", {txd, busy}, 1);
    brk_force = 1'b0;
    #1;
    check(txd == 1'b1, "R9", txd, 1);
    wait_to(160);
    brk_force = 1'b1;
    accept_char(8'hFF);
    check(busy == 1'b1, "R9", busy, 1);
    wait_to(100);
    check(txd == 1'b0, "R9", txd, 0);
    brk_force = 1'b0;
    #1;
    check(txd == 1'b1, "R9", txd, 1);
    wait_to(160);
    check(busy == 1'b0 && txd == 1'b1, "R9", {busy, txd}, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule